// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a local register-bus master and an outbound PCI bridge window. A master hands it one configuration request at a time: bus, device, function, register offset, access size, direction and write data. The block decides whether the request is a Type 0 access (local segment) or a Type 1 access (forwarded through bridges), forms the 32-bit downstream address, and issues a one-cycle write of the matching window-select value before the access itself. Type 0 accesses pick the target device with a one-hot select bit. The part of that bit that falls inside the window mask goes into the window value, and the rest goes into the address.

Sub-word accesses are aligned in the block. Read data is shifted down to bit 0 and trimmed to the access size. Byte and halfword writes are done as a read of the whole word, a lane merge and a write-back. Requests the block cannot decode are answered at once with an error code and reach neither the window nor the downstream port. A bus error reported downstream yields all-ones data and an error code, and any pending write-back is dropped.

Top module: `cfg_xlat`

## Requirements
- R1: `req_ready` is high only while idle. It goes low in the cycle after a request is accepted and stays low until `resp_valid` has been shown for exactly one cycle, so exactly one response is returned per request.
- R2: With bus 0 (Type 0), the select bit is bit (device+16). The window value is `0x0000_0002` ORed with the select bit masked by `0xFC00_0000`. The address is `0x0C00_0000` ORed with the select bit outside that mask, function<<8 and the offset with bits 1:0 cleared. The window write (`win_we` for one cycle) comes immediately before the downstream request.
- R3: With a nonzero bus (Type 1), the window value is `0x0000_0003` and the address is `0x0C00_0000` | bus<<16 | device<<11 | function<<8 | (offset with bits 1:0 cleared).
- R4: A Type 0 request with device 16 or above is rejected. `resp_valid` rises in the cycle after acceptance with `resp_err` = 1 (invalid), and neither `win_we` nor `ds_req` is raised.
- R5: While `single_slot` is high, any request with device above 1 is rejected as in R4. Device 0 and device 1 are still translated.
- R6: `req_len` is a byte count. Only 1, 2 and 4 are legal. Any other value is rejected as in R4.
- R7: Read data equals the downstream word shifted right by 8×(offset mod 4), then masked to the low `req_len` bytes. `resp_err` = 0 on success.
- R8: A 1- or 2-byte write issues one downstream read and then one downstream write to the same address. The written word is the read word with the addressed lanes replaced by the new data shifted left by 8×(offset mod 4).
- R9: A 4-byte write issues a single downstream write of `req_wdata` and no downstream read.
- R10: If `ds_berr` accompanies `ds_ack`, the response carries `resp_err` = 2 (bus error). A read returns `0xFFFF_FFFF`. A merge read that fails suppresses the write-back.
- R11: `ds_req` stays high with stable `ds_addr` and `ds_we` until `ds_ack`, and `ds_addr` always has bits 1:0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_slot | input | 1 | Restricts decoding to devices 0 and 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_len | input | 3 | Access size in bytes |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| win_we | output | 1 | Window-select write strobe |
| win_val | output | 32 | Window-select value |
| ds_req | output | 1 | Downstream access request |
| ds_we | output | 1 | Downstream access is a write |
| ds_addr | output | 32 | Downstream word address |
| ds_wdata | output | 32 | Downstream write data |
| ds_ack | input | 1 | Downstream access complete |
| ds_rdata | input | 32 | Downstream read data, valid with ack |
| ds_berr | input | 1 | Downstream bus error, valid with ack |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 32 | Aligned read data |
| resp_err | output | 2 | 0 ok, 1 invalid request, 2 bus error |

## Verification
The checker watches the handshake and ordering rules on every cycle. These are: the busy period after acceptance, the next-cycle rejection of bad sizes and out-of-range Type 0 devices, the window strobe directly preceding a downstream request, the request being held steady until acknowledged, word-aligned addresses, and the response that follows a bus error. The exact address and window values, the shifted read data, the merged write word, the single-slot restriction and whether a downstream read occurred at all can only be shown by the bench scenarios, which compare against values worked out by hand.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_INVALID = 2'd1,
    RSP_BUSERR  = 2'd2
  } rsp_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_RD,
    ST_WR,
    ST_RESP
  } xlat_state_e;

endpackage

// File: rtl/cfg_addr_decode.sv
// Combinational decode of a configuration request into window value,
// downstream address and a reject flag.
module cfg_addr_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          BUS_W     = 8,
  parameter int          DEV_W     = 5,
  parameter int          FUNC_W    = 3,
  parameter int          OFF_W     = 8,
  parameter int          LEN_W     = 3,
  parameter int          IDSEL_LSB = 16,
  parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
  parameter logic [31:0] WIN_TYPE0 = 32'h0000_0002,
  parameter logic [31:0] WIN_TYPE1 = 32'h0000_0003
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic              single_slot,
  output logic              reject,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] win
);

  localparam int SLOT_MAX = ADDR_W - IDSEL_LSB;

  logic              type1;
  logic              len_ok;
  logic              slot_ok;
  logic              single_ok;
  logic [ADDR_W-1:0] idsel;
  logic [ADDR_W-1:0] common;

  always_comb begin
    type1     = (bus != '0);
    len_ok    = (len == LEN_W'(1)) || (len == LEN_W'(2)) || (len == LEN_W'(4));
    slot_ok   = type1 || (int'(dev) < SLOT_MAX);
    single_ok = !single_slot || (int'(dev) <= 1);
    reject    = !(len_ok && slot_ok && single_ok);

    idsel = '0;
    if (!type1 && (int'(dev) < SLOT_MAX))
      idsel = ADDR_W'(1) << (int'(dev) + IDSEL_LSB);

    common = CFG_BASE[ADDR_W-1:0]
           | (ADDR_W'(func) << 8)
           | (ADDR_W'(off) & ~ADDR_W'(3));

    if (type1) begin
      addr = common | (ADDR_W'(bus) << 16) | (ADDR_W'(dev) << 11);
      win  = WIN_TYPE1[ADDR_W-1:0];
    end else begin
      addr = common | (idsel & ~WIN_MASK[ADDR_W-1:0]);
      win  = WIN_TYPE0[ADDR_W-1:0] | (idsel & WIN_MASK[ADDR_W-1:0]);
    end
  end

endmodule

// File: rtl/cfg_lane_align.sv
// Byte-lane alignment: read extraction and partial-write merge.
module cfg_lane_align #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [DATA_W-1:0]         word,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [LEN_W-1:0]          len,
  output logic [DATA_W-1:0]         rd_aligned,
  output logic [DATA_W-1:0]         merged
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] lane_mask;

  always_comb begin
    shamt = {lane, 3'b000};
    unique case (len)
      LEN_W'(1): size_mask = DATA_W'(8'hFF);
      LEN_W'(2): size_mask = DATA_W'(16'hFFFF);
      default:   size_mask = '1;
    endcase
    lane_mask  = size_mask << shamt;
    rd_aligned = (word >> shamt) & size_mask;
    merged     = (word & ~lane_mask) | ((wdata & size_mask) << shamt);
  end

endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          BUS_W     = 8,
  parameter int          DEV_W     = 5,
  parameter int          FUNC_W    = 3,
  parameter int          OFF_W     = 8,
  parameter int          LEN_W     = 3,
  parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
  parameter logic [31:0] WIN_TYPE0 = 32'h0000_0002,
  parameter logic [31:0] WIN_TYPE1 = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_slot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              win_we,
  output logic [ADDR_W-1:0] win_val,
  output logic              ds_req,
  output logic              ds_we,
  output logic [ADDR_W-1:0] ds_addr,
  output logic [DATA_W-1:0] ds_wdata,
  input  logic              ds_ack,
  input  logic [DATA_W-1:0] ds_rdata,
  input  logic              ds_berr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [1:0]        resp_err
);

  localparam int LANE_W = $clog2(DATA_W/8);

  xlat_state_e       st_q, st_d;
  logic              fire;
  logic              dec_reject;
  logic [ADDR_W-1:0] dec_addr, dec_win;
  logic [DATA_W-1:0] rd_aligned, merged;

  logic [ADDR_W-1:0] addr_q, win_q;
  logic [DATA_W-1:0] wbuf_q, wbuf_d, rdata_q, rdata_d;
  logic [LEN_W-1:0]  len_q;
  logic [LANE_W-1:0] lane_q;
  logic              we_q;
  rsp_code_e         err_q, err_d;
  logic              cap_en, wbuf_en, rsp_en;

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
    .OFF_W(OFF_W), .LEN_W(LEN_W), .IDSEL_LSB(16),
    .CFG_BASE(CFG_BASE), .WIN_MASK(WIN_MASK),
    .WIN_TYPE0(WIN_TYPE0), .WIN_TYPE1(WIN_TYPE1)
  ) u_decode (
    .bus(req_bus), .dev(req_dev), .func(req_func), .off(req_off),
    .len(req_len), .single_slot(single_slot),
    .reject(dec_reject), .addr(dec_addr), .win(dec_win)
  );

  cfg_lane_align #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_lanes (
    .word(ds_rdata), .wdata(wbuf_q), .lane(lane_q), .len(len_q),
    .rd_aligned(rd_aligned), .merged(merged)
  );

  assign fire = req_valid && (st_q == ST_IDLE);

  // Next-state and data-path enables
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    wbuf_en = 1'b0;
    wbuf_d  = merged;
    rsp_en  = 1'b0;
    rdata_d = '0;
    err_d   = RSP_OK;
    unique case (st_q)
      ST_IDLE: if (fire) begin
        cap_en = 1'b1;
        if (dec_reject) begin
          st_d   = ST_RESP;
          rsp_en = 1'b1;
          err_d  = RSP_INVALID;
        end else begin
          st_d = ST_WIN;
        end
      end
      ST_WIN: st_d = (we_q && (len_q == LEN_W'(4))) ? ST_WR : ST_RD;
      ST_RD: if (ds_ack) begin
        if (ds_berr) begin
          st_d    = ST_RESP;
          rsp_en  = 1'b1;
          rdata_d = '1;
          err_d   = RSP_BUSERR;
        end else if (we_q) begin
          st_d    = ST_WR;
          wbuf_en = 1'b1;
        end else begin
          st_d    = ST_RESP;
          rsp_en  = 1'b1;
          rdata_d = rd_aligned;
        end
      end
      ST_WR: if (ds_ack) begin
        st_d   = ST_RESP;
        rsp_en = 1'b1;
        err_d  = ds_berr ? RSP_BUSERR : RSP_OK;
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // Data registers: no reset, loaded only under their enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= dec_addr;
      win_q  <= dec_win;
      len_q  <= req_len;
      lane_q <= req_off[LANE_W-1:0];
      we_q   <= req_we;
    end
    if (cap_en)       wbuf_q <= req_wdata;
    else if (wbuf_en) wbuf_q <= wbuf_d;
    if (rsp_en) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign win_we     = (st_q == ST_WIN);
  assign win_val    = win_q;
  assign ds_req     = (st_q == ST_RD) || (st_q == ST_WR);
  assign ds_we      = (st_q == ST_WR);
  assign ds_addr    = addr_q;
  assign ds_wdata   = wbuf_q;
  assign resp_valid = (st_q == ST_RESP);
  assign resp_rdata = rdata_q;
  assign resp_err   = err_q;

endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BUS_W-1:0]  req_bus,
  input logic [DEV_W-1:0]  req_dev,
  input logic [LEN_W-1:0]  req_len,
  input logic              win_we,
  input logic              ds_req,
  input logic              ds_we,
  input logic [ADDR_W-1:0] ds_addr,
  input logic              ds_ack,
  input logic              ds_berr,
  input logic              resp_valid,
  input logic [31:0]       resp_rdata,
  input logic [1:0]        resp_err
);

  localparam int SLOT_MAX = ADDR_W - 16;

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_bad_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len != 3'd1) && (req_len != 3'd2) && (req_len != 3'd4)
    |=> resp_valid && (resp_err == 2'd1) && !win_we && !ds_req);

  p_bad_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_bus == '0) && (int'(req_dev) >= SLOT_MAX)
    |=> resp_valid && (resp_err == 2'd1) && !win_we && !ds_req);

  p_win_before_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_we |=> ds_req);

  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && !ds_ack |=> ds_req && $stable(ds_addr) && $stable(ds_we));

  p_word_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req |-> (ds_addr[1:0] == 2'b00));

  p_berr_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && ds_ack && ds_berr |=> resp_valid && (resp_err == 2'd2) && !ds_req);

  p_berr_read_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && !ds_we && ds_ack && ds_berr |=> (resp_rdata == 32'hFFFF_FFFF));

endmodule

bind cfg_xlat cfg_xlat_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/cfg_xlat_tb.sv
`timescale 1ns/1ps
module cfg_xlat_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        single_slot;
  logic        req_valid, req_ready;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [7:0]  req_off;
  logic [2:0]  req_len;
  logic        req_we;
  logic [31:0] req_wdata;
  logic        win_we;
  logic [31:0] win_val;
  logic        ds_req, ds_we;
  logic [31:0] ds_addr, ds_wdata;
  logic        ds_ack;
  logic [31:0] ds_rdata;
  logic        ds_berr;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic [1:0]  resp_err;

  always #2 clk = ~clk;

  cfg_xlat u_dut (.*);

  // Downstream model
  logic [31:0] model_word;
  logic        berr_inj;
  logic [1:0]  lat;
  int          n_rd, n_wr, n_win, n_hold_err;
  logic [31:0] last_raddr, last_waddr, last_wdata, last_win, first_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_ack <= 1'b0; ds_berr <= 1'b0; ds_rdata <= '0; lat <= '0;
      n_rd <= 0; n_wr <= 0; n_win <= 0; n_hold_err <= 0;
    end else begin
      ds_ack <= 1'b0;
      if (ds_req && !ds_ack) begin
        if (lat == 2'd0) first_addr <= ds_addr;
        if (lat == 2'd1) begin
          lat      <= '0;
          ds_ack   <= 1'b1;
          ds_rdata <= model_word;
          ds_berr  <= berr_inj;
          if (ds_addr != first_addr) n_hold_err <= n_hold_err + 1;
          if (ds_we) begin
            n_wr <= n_wr + 1; last_waddr <= ds_addr; last_wdata <= ds_wdata;
          end else begin
            n_rd <= n_rd + 1; last_raddr <= ds_addr;
          end
        end else lat <= lat + 2'd1;
      end
      if (win_we) begin
        n_win <= n_win + 1; last_win <= win_val;
      end
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [7:0] o, input logic [2:0] l, input logic w,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic [1:0] er, output int cyc, output logic rdy_after);
    @(negedge clk);
    req_bus = b; req_dev = d; req_func = f; req_off = o; req_len = l;
    req_we = w; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = req_ready;
    cyc = 1;
    while (!resp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 60) begin
      checks++; fails++;
      $display("FAIL R1 no response actual=timeout expected=resp_valid");
    end
    rd = resp_rdata; er = resp_err;
    @(negedge clk);
  endtask

  logic [31:0] rd;
  logic [1:0]  er;
  int          cyc;
  logic        rdy;

  task automatic t_reset;
    check("R1 reset ready", {31'b0, req_ready}, 32'd1);
    check("R1 reset resp_valid", {31'b0, resp_valid}, 32'd0);
    check("R11 reset ds_req", {31'b0, ds_req}, 32'd0);
    check("R2 reset win_we", {31'b0, win_we}, 32'd0);
  endtask

  task automatic t_type0_read;
    model_word = 32'hA1B2C3D4;
    do_req(8'd0, 5'd3, 3'd2, 8'h0E, 3'd2, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R1 ready low after accept", {31'b0, rdy}, 32'd0);
    check("R2 type0 address", last_raddr, 32'h0C08_020C);
    check("R2 type0 window", last_win, 32'h0000_0002);
    check("R7 halfword read", rd, 32'h0000_A1B2);
    check("R7 ok code", {30'b0, er}, 32'd0);
    do_req(8'd0, 5'd12, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R2 masked select in window", last_win, 32'h1000_0002);
    check("R2 masked select not in address", last_raddr, 32'h0C00_0000);
    check("R7 word read", rd, 32'hA1B2_C3D4);
  endtask

  task automatic t_type1_read;
    model_word = 32'hA1B2C3D4;
    do_req(8'd5, 5'd20, 3'd7, 8'h3D, 3'd1, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R3 type1 address", last_raddr, 32'h0C05_A73C);
    check("R3 type1 window", last_win, 32'h0000_0003);
    check("R7 byte read lane1", rd, 32'h0000_00C3);
  endtask

  task automatic t_bad_dev;
    int r0, w0, n0;
    r0 = n_rd; w0 = n_wr; n0 = n_win;
    do_req(8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R4 invalid code", {30'b0, er}, 32'd1);
    check("R4 response next cycle", cyc, 32'd1);
    check("R4 no downstream access", n_rd + n_wr + n_win, r0 + w0 + n0);
  endtask

  task automatic t_single_slot;
    int n0;
    single_slot = 1'b1;
    n0 = n_rd + n_wr + n_win;
    do_req(8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R5 device 2 rejected", {30'b0, er}, 32'd1);
    check("R5 no access", n_rd + n_wr + n_win, n0);
    model_word = 32'h0102_0304;
    do_req(8'd0, 5'd1, 3'd0, 8'h10, 3'd4, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R5 device 1 allowed", {30'b0, er}, 32'd0);
    check("R5 device 1 address", last_raddr, 32'h0C02_0010);
    single_slot = 1'b0;
  endtask

  task automatic t_bad_len;
    do_req(8'd0, 5'd0, 3'd0, 8'h00, 3'd3, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R6 length 3 rejected", {30'b0, er}, 32'd1);
    check("R6 response next cycle", cyc, 32'd1);
    do_req(8'd1, 5'd0, 3'd0, 8'h00, 3'd0, 1'b1, 32'h0, rd, er, cyc, rdy);
    check("R6 length 0 rejected", {30'b0, er}, 32'd1);
  endtask

  task automatic t_rmw;
    int r0, w0;
    model_word = 32'h1122_3344;
    r0 = n_rd; w0 = n_wr;
    do_req(8'd0, 5'd0, 3'd1, 8'h05, 3'd1, 1'b1, 32'h0000_00AB, rd, er, cyc, rdy);
    check("R8 one read", n_rd - r0, 32'd1);
    check("R8 one write", n_wr - w0, 32'd1);
    check("R8 write address", last_waddr, 32'h0C01_0104);
    check("R8 byte merge", last_wdata, 32'h1122_AB44);
    do_req(8'd0, 5'd0, 3'd1, 8'h06, 3'd2, 1'b1, 32'h0000_BEEF, rd, er, cyc, rdy);
    check("R8 halfword merge", last_wdata, 32'hBEEF_3344);
  endtask

  task automatic t_word_write;
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    do_req(8'd1, 5'd0, 3'd0, 8'h40, 3'd4, 1'b1, 32'hDEAD_BEEF, rd, er, cyc, rdy);
    check("R9 no read", n_rd - r0, 32'd0);
    check("R9 one write", n_wr - w0, 32'd1);
    check("R9 direct data", last_wdata, 32'hDEAD_BEEF);
    check("R9 address", last_waddr, 32'h0C01_0040);
  endtask

  task automatic t_berr;
    int w0;
    berr_inj = 1'b1;
    do_req(8'd0, 5'd4, 3'd0, 8'h02, 3'd1, 1'b0, 32'h0, rd, er, cyc, rdy);
    check("R10 read all ones", rd, 32'hFFFF_FFFF);
    check("R10 read bus error code", {30'b0, er}, 32'd2);
    w0 = n_wr;
    do_req(8'd0, 5'd4, 3'd0, 8'h01, 3'd1, 1'b1, 32'h55, rd, er, cyc, rdy);
    check("R10 write-back suppressed", n_wr - w0, 32'd0);
    check("R10 write bus error code", {30'b0, er}, 32'd2);
    berr_inj = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; single_slot = 1'b0; req_valid = 1'b0;
    req_bus = '0; req_dev = '0; req_func = '0; req_off = '0; req_len = '0;
    req_we = 1'b0; req_wdata = '0; model_word = '0; berr_inj = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0_read();
    t_type1_read();
    t_bad_dev();
    t_single_slot();
    t_bad_len();
    t_rmw();
    t_word_write();
    t_berr();
    check("R11 address held until ack", n_hold_err, 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule